// File: doc/BRIEF.md
# Coprocessor Word Transfer Sequencer

This controller executes a single coprocessor load (memory to coprocessor) or store (coprocessor to memory) instruction once the instruction has been decoded. It takes the following inputs with a start pulse: a direction bit, a coprocessor number, the base register value, an 8-bit word offset, an add/subtract bit, a pre/post-index bit and a writeback bit. Before it talks to anyone, the controller checks that the selected coprocessor exists and that access to it is permitted. If not, the instruction ends as an undefined-instruction trap.

If the check passes, the controller asks the coprocessor a first question. It keeps polling while the answer is busy. A poll is marked as an interrupt-phase poll whenever an interrupt is pending. When the coprocessor accepts, a load signals a transfer phase first. The controller then moves words one per beat between a word-wide memory port and the coprocessor, 4 bytes further on for each beat, for as long as the coprocessor answers "more".

A refused instruction ends as an undefined-instruction trap. A memory fault ends it as a data abort. Otherwise the instruction finishes normally. When writeback is enabled, the updated base goes out once the coprocessor accepts. If a later beat faults, the original base goes out again.

Top module: `cp_xfer_seq`

## Requirements
- R1: After reset the block is idle: busy, cp_req, mem_req, xfer_done, trap_undef, abort_data and wb_en are all 0.
- R2: When the selected coprocessor is absent (cp_present bit 0) or not permitted (cp_allowed bit 0), the instruction ends with trap_undef and makes no coprocessor query and no memory access.
- R3: The first query carries phase code 0. Each following poll after a busy answer (cp_resp 1) carries phase code 2 when irq_pending is 1 and phase code 1 otherwise.
- R4: A refusal (cp_resp 2) to any query ends the instruction with trap_undef and no memory access.
- R5: For a load, once the coprocessor accepts, exactly one transfer-phase request (phase code 3) is made. Then each word read from memory is handed to the coprocessor on cp_wdata in a data-phase request (phase code 4). Reading continues while the answer is "more" (cp_resp 3).
- R6: Each beat after the first uses an address 4 bytes above the previous beat's address.
- R7: For a store, each data-phase request takes cp_rdata and writes it to memory in the same cycle (mem_we 1). Further beats follow while the answer is "more".
- R8: A memory fault on any beat ends the instruction with abort_data, and no further memory access is made.
- R9: When op_wback is 1, a wb_en pulse carries the target base (base plus or minus 4 times the offset) the cycle after acceptance. After a fault, a second pulse restores the original base. When op_wback is 0, wb_en stays 0.
- R10: With op_pre 1 the first beat uses the target base; with op_pre 0 it uses the raw base. op_up 1 adds the scaled offset and op_up 0 subtracts it.
- R11: A start pulse while busy is 1 has no effect on the running instruction.
- R12: Exactly one of xfer_done, trap_undef or abort_data pulses for one cycle, in the cycle after the deciding cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction (taken only when idle) |
| op_store | input | 1 | 1 = store, 0 = load |
| op_cp | input | CPW | Coprocessor number |
| op_base | input | AW | Base register value |
| op_off | input | OFFW | Offset in words |
| op_up | input | 1 | 1 = add offset, 0 = subtract |
| op_pre | input | 1 | 1 = pre-indexed, 0 = post-indexed |
| op_wback | input | 1 | Write back the updated base |
| cp_present | input | NCP | One bit per coprocessor slot that is fitted |
| cp_allowed | input | NCP | One bit per coprocessor slot whose access is permitted |
| irq_pending | input | 1 | Interrupt pending |
| cp_req | output | 1 | Coprocessor request valid |
| cp_phase | output | 3 | 0 first, 1 busy poll, 2 interrupt poll, 3 transfer, 4 data |
| cp_sel | output | CPW | Selected coprocessor |
| cp_resp | input | 2 | Same-cycle answer: 0 done, 1 busy, 2 refuse, 3 more |
| cp_wdata | output | DW | Load word handed to the coprocessor |
| cp_rdata | input | DW | Store word from the coprocessor |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | 1 = write |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Same-cycle read data |
| mem_fault | input | 1 | Same-cycle fault for the current access |
| busy | output | 1 | Instruction in progress |
| xfer_done | output | 1 | Normal completion pulse |
| trap_undef | output | 1 | Undefined-instruction trap pulse |
| abort_data | output | 1 | Data abort pulse |
| wb_en | output | 1 | Base register write pulse |
| wb_value | output | AW | Base register write value |

## Verification
Coprocessor requests and memory accesses are combinational in the state entered at the edge that samples start. The first query is therefore seen in cycle 1. After acceptance, a load spends one transfer cycle before its first beat, while a store begins beats at once.

A result pulse is due in cycle busy-count + 2 for a refusal, cycle 2 for a permission trap, and cycle busy-count + 2 + beats completed (+1 for loads) otherwise. The monitor counts falling edges from the start cycle and compares its count with that figure when the pulse arrives. Addresses, store data and writeback values are compared in arrival order against queues that the driver fills from the requirements.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

  typedef enum logic [2:0] {
    PH_FIRST = 3'd0,
    PH_POLL  = 3'd1,
    PH_INTR  = 3'd2,
    PH_XFER  = 3'd3,
    PH_DATA  = 3'd4
  } cpx_phase_e;

  typedef enum logic [1:0] {
    RS_DONE = 2'd0,
    RS_BUSY = 2'd1,
    RS_CANT = 2'd2,
    RS_MORE = 2'd3
  } cpx_resp_e;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_ASK   = 3'd1,
    SQ_WAIT  = 3'd2,
    SQ_XFER  = 3'd3,
    SQ_BEAT  = 3'd4
  } cpx_state_e;

endpackage

// File: rtl/cpx_addr_gen.sv
module cpx_addr_gen #(
  parameter int AW    = 32,
  parameter int OFFW  = 8,
  parameter int SHIFT = 2
) (
  input  logic [AW-1:0]   base,
  input  logic [OFFW-1:0] off,
  input  logic            up,
  input  logic            pre,
  output logic [AW-1:0]   first_addr,
  output logic [AW-1:0]   tgt_addr
);
  localparam int PADW = AW - OFFW - SHIFT;

  logic [AW-1:0] scaled;

  // offset counts words; scale it to bytes
  assign scaled     = {{PADW{1'b0}}, off, {SHIFT{1'b0}}};
  assign tgt_addr   = up ? (base + scaled) : (base - scaled);
  assign first_addr = pre ? tgt_addr : base;

endmodule

// File: rtl/cpx_perm_chk.sv
module cpx_perm_chk #(
  parameter int NCP = 16,
  parameter int CPW = 4
) (
  input  logic [NCP-1:0] present,
  input  logic [NCP-1:0] allowed,
  input  logic [CPW-1:0] sel,
  output logic           ok
);
  logic [NCP-1:0] grant;

  for (genvar i = 0; i < NCP; i++) begin : g_slot
    assign grant[i] = present[i] & allowed[i];
  end

  always_comb begin
    ok = 1'b0;
    for (int j = 0; j < NCP; j++) begin
      if (sel == CPW'(j)) ok = grant[j];
    end
  end

endmodule

// File: rtl/cpx_ctrl.sv
module cpx_ctrl
  import cpx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       perm_ok,
  input  logic       is_store,
  input  logic       irq,
  input  logic [1:0] resp,
  input  logic       mem_fault,
  output logic       latch,
  output logic       busy,
  output logic       cp_req,
  output logic [2:0] cp_phase,
  output logic       mem_req,
  output logic       mem_we,
  output logic       adv,
  output logic       accept,
  output logic       fin_done,
  output logic       fin_trap,
  output logic       fin_abort
);
  cpx_state_e state_q, state_d;
  cpx_resp_e  rs;

  assign rs   = cpx_resp_e'(resp);
  assign busy = (state_q != SQ_IDLE);

  always_comb begin
    state_d   = state_q;
    latch     = 1'b0;
    cp_req    = 1'b0;
    cp_phase  = PH_FIRST;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    adv       = 1'b0;
    accept    = 1'b0;
    fin_done  = 1'b0;
    fin_trap  = 1'b0;
    fin_abort = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (start) begin
          latch   = 1'b1;
          state_d = SQ_ASK;
        end
      end
      SQ_ASK, SQ_WAIT: begin
        if (state_q == SQ_ASK && !perm_ok) begin
          fin_trap = 1'b1;
          state_d  = SQ_IDLE;
        end else begin
          cp_req = 1'b1;
          if (state_q == SQ_ASK) cp_phase = PH_FIRST;
          else                   cp_phase = irq ? PH_INTR : PH_POLL;
          if (rs == RS_BUSY) begin
            state_d = SQ_WAIT;
          end else if (rs == RS_CANT) begin
            fin_trap = 1'b1;
            state_d  = SQ_IDLE;
          end else begin
            accept  = 1'b1;
            state_d = is_store ? SQ_BEAT : SQ_XFER;
          end
        end
      end
      SQ_XFER: begin
        cp_req   = 1'b1;
        cp_phase = PH_XFER;
        state_d  = SQ_BEAT;
      end
      SQ_BEAT: begin
        mem_req  = 1'b1;
        mem_we   = is_store;
        cp_phase = PH_DATA;
        // a load only forwards a word that arrived without fault
        cp_req   = is_store | ~mem_fault;
        if (mem_fault) begin
          fin_abort = 1'b1;
          state_d   = SQ_IDLE;
        end else if (rs == RS_MORE) begin
          adv = 1'b1;
        end else begin
          fin_done = 1'b1;
          state_d  = SQ_IDLE;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/cp_xfer_seq.sv
module cp_xfer_seq #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int NCP  = 16,
  parameter int OFFW = 8,
  parameter int CPW  = $clog2(NCP)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            op_store,
  input  logic [CPW-1:0]  op_cp,
  input  logic [AW-1:0]   op_base,
  input  logic [OFFW-1:0] op_off,
  input  logic            op_up,
  input  logic            op_pre,
  input  logic            op_wback,
  input  logic [NCP-1:0]  cp_present,
  input  logic [NCP-1:0]  cp_allowed,
  input  logic            irq_pending,
  output logic            cp_req,
  output logic [2:0]      cp_phase,
  output logic [CPW-1:0]  cp_sel,
  input  logic [1:0]      cp_resp,
  output logic [DW-1:0]   cp_wdata,
  input  logic [DW-1:0]   cp_rdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_fault,
  output logic            busy,
  output logic            xfer_done,
  output logic            trap_undef,
  output logic            abort_data,
  output logic            wb_en,
  output logic [AW-1:0]   wb_value
);
  localparam int BYTES = DW / 8;
  localparam int SHIFT = $clog2(BYTES);

  logic            latch, adv, accept, perm_ok;
  logic            fin_done, fin_trap, fin_abort;
  logic [AW-1:0]   first_addr, tgt_addr;

  logic            store_q, wback_q;
  logic [CPW-1:0]  cp_q;
  logic [AW-1:0]   base_q, tgt_q, addr_q;

  logic            done_q, trap_q, abort_q, wb_en_q;
  logic [AW-1:0]   wb_val_q;

  cpx_addr_gen #(.AW(AW), .OFFW(OFFW), .SHIFT(SHIFT)) u_addr (
    .base       (op_base),
    .off        (op_off),
    .up         (op_up),
    .pre        (op_pre),
    .first_addr (first_addr),
    .tgt_addr   (tgt_addr)
  );

  cpx_perm_chk #(.NCP(NCP), .CPW(CPW)) u_perm (
    .present (cp_present),
    .allowed (cp_allowed),
    .sel     (cp_q),
    .ok      (perm_ok)
  );

  cpx_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .perm_ok   (perm_ok),
    .is_store  (store_q),
    .irq       (irq_pending),
    .resp      (cp_resp),
    .mem_fault (mem_fault),
    .latch     (latch),
    .busy      (busy),
    .cp_req    (cp_req),
    .cp_phase  (cp_phase),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .adv       (adv),
    .accept    (accept),
    .fin_done  (fin_done),
    .fin_trap  (fin_trap),
    .fin_abort (fin_abort)
  );

  // instruction capture and beat address
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= 1'b0;
      wback_q <= 1'b0;
      cp_q    <= '0;
      base_q  <= '0;
      tgt_q   <= '0;
      addr_q  <= '0;
    end else if (latch) begin
      store_q <= op_store;
      wback_q <= op_wback;
      cp_q    <= op_cp;
      base_q  <= op_base;
      tgt_q   <= tgt_addr;
      addr_q  <= first_addr;
    end else if (adv) begin
      addr_q  <= addr_q + AW'(BYTES);
    end
  end

  // registered results and base writeback
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      trap_q   <= 1'b0;
      abort_q  <= 1'b0;
      wb_en_q  <= 1'b0;
      wb_val_q <= '0;
    end else begin
      done_q  <= fin_done;
      trap_q  <= fin_trap;
      abort_q <= fin_abort;
      wb_en_q <= wback_q & (accept | fin_abort);
      if (wback_q && accept)         wb_val_q <= tgt_q;
      else if (wback_q && fin_abort) wb_val_q <= base_q;
    end
  end

  assign cp_sel     = cp_q;
  assign cp_wdata   = mem_rdata;
  assign mem_addr   = addr_q;
  assign mem_wdata  = cp_rdata;
  assign xfer_done  = done_q;
  assign trap_undef = trap_q;
  assign abort_data = abort_q;
  assign wb_en      = wb_en_q;
  assign wb_value   = wb_val_q;

endmodule

// File: rtl/cpx_seq_chk.sv
module cpx_seq_chk
  import cpx_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_pending,
  input logic          cp_req,
  input logic [2:0]    cp_phase,
  input logic [1:0]    cp_resp,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_fault,
  input logic          busy,
  input logic          xfer_done,
  input logic          trap_undef,
  input logic          abort_data
);
  localparam int BYTES = DW / 8;

  logic is_query;
  assign is_query = cp_req && (cp_phase == PH_FIRST || cp_phase == PH_POLL ||
                               cp_phase == PH_INTR);

  // R3
  poll_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_query && cp_resp == RS_BUSY |=>
      cp_req && cp_phase == (irq_pending ? PH_INTR : PH_POLL));

  // R4
  refuse_traps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_query && cp_resp == RS_CANT |=> trap_undef && !mem_req);

  // R6
  beat_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_fault && cp_req && cp_phase == PH_DATA && cp_resp == RS_MORE
      |=> mem_req && mem_addr == $past(mem_addr) + AW'(BYTES));

  // R8
  fault_aborts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_fault |=> abort_data && !busy && !mem_req);

  // R12
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xfer_done, trap_undef, abort_data}));

  // R12
  result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done || trap_undef || abort_data) |=> !(xfer_done || trap_undef || abort_data));

endmodule

bind cp_xfer_seq cpx_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_pending (irq_pending),
  .cp_req      (cp_req),
  .cp_phase    (cp_phase),
  .cp_resp     (cp_resp),
  .mem_req     (mem_req),
  .mem_addr    (mem_addr),
  .mem_fault   (mem_fault),
  .busy        (busy),
  .xfer_done   (xfer_done),
  .trap_undef  (trap_undef),
  .abort_data  (abort_data)
);

// File: tb/sim_cp_xfer_seq.sv
`timescale 1ns/100ps
module sim_cp_xfer_seq;
  localparam int AW = 32, DW = 32, NCP = 16, OFFW = 8, CPW = 4;

  logic clk, rst_n, start, op_store, op_up, op_pre, op_wback, irq_pending;
  logic [CPW-1:0] op_cp, cp_sel;
  logic [AW-1:0] op_base, mem_addr, wb_value;
  logic [OFFW-1:0] op_off;
  logic [NCP-1:0] cp_present, cp_allowed;
  logic cp_req, mem_req, mem_we, mem_fault, busy, xfer_done, trap_undef, abort_data, wb_en;
  logic [2:0] cp_phase;
  logic [1:0] cp_resp;
  logic [DW-1:0] cp_wdata, cp_rdata, mem_wdata, mem_rdata;

  cp_xfer_seq u0 (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // responder configuration and counters
  int cfg_busy, cfg_beats, cfg_fault;
  bit cfg_cant, cur_store;
  int q_cnt, beat_cnt, n_first, n_poll, n_intr, n_xfer;

  always_comb begin
    cp_resp = 2'd0;
    if (cp_req) begin
      if (cp_phase <= 3'd2)
        cp_resp = (q_cnt < cfg_busy) ? 2'd1 : (cfg_cant ? 2'd2 : 2'd0);
      else if (cp_phase == 3'd4)
        cp_resp = (beat_cnt < cfg_beats - 1) ? 2'd3 : 2'd0;
    end
  end
  assign mem_fault = mem_req && (beat_cnt == cfg_fault);
  assign mem_rdata = mem_addr ^ 32'h5A5A_0000;
  assign cp_rdata  = 32'hC0DE_0000 + 32'(beat_cnt);

  always @(posedge clk) begin
    if (start && !busy) begin
      q_cnt <= 0; beat_cnt <= 0; n_first <= 0; n_poll <= 0; n_intr <= 0; n_xfer <= 0;
    end else if (cp_req) begin
      case (cp_phase)
        3'd0: begin q_cnt <= q_cnt + 1; n_first <= n_first + 1; end
        3'd1: begin q_cnt <= q_cnt + 1; n_poll <= n_poll + 1; end
        3'd2: begin q_cnt <= q_cnt + 1; n_intr <= n_intr + 1; end
        3'd3: n_xfer <= n_xfer + 1;
        3'd4: beat_cnt <= beat_cnt + 1;
        default: ;
      endcase
    end
  end

  // scoreboard queues
  logic [31:0] exp_addr[$], exp_wd[$], exp_wb[$];
  int exp_res[$];          // 0 done, 1 trap, 2 abort
  int exp_lat, cyc;
  bit got;

  always @(negedge clk) begin
    if (start && !busy) cyc = 0; else cyc++;
    if (mem_req) begin
      if (exp_addr.size() == 0) chk(0, "R2/R8", "unexpected memory access", mem_addr, 0);
      else begin
        logic [31:0] a;
        a = exp_addr.pop_front();
        chk(mem_addr == a, "R6/R10", "beat address", mem_addr, a);
        chk(mem_we == cur_store, "R7", "write enable", 32'(mem_we), 32'(cur_store));
        if (cur_store) begin
          logic [31:0] d;
          d = exp_wd.pop_front();
          chk(mem_wdata == d, "R7", "store data", mem_wdata, d);
        end else if (!mem_fault) begin
          chk(cp_req && cp_phase == 3'd4 && cp_wdata == (mem_addr ^ 32'h5A5A_0000),
              "R5", "load word to coprocessor", cp_wdata, mem_addr ^ 32'h5A5A_0000);
        end
      end
    end
    if (wb_en) begin
      if (exp_wb.size() == 0) chk(0, "R9", "unexpected writeback", wb_value, 0);
      else begin
        logic [31:0] w;
        w = exp_wb.pop_front();
        chk(wb_value == w, "R9", "writeback value", wb_value, w);
      end
    end
    if (xfer_done || trap_undef || abort_data) begin
      int r, act;
      act = xfer_done ? 0 : (trap_undef ? 1 : 2);
      r = (exp_res.size() != 0) ? exp_res.pop_front() : -1;
      chk(act == r && 32'($countones({xfer_done, trap_undef, abort_data})) == 1,
          "R12/R4/R8", "result kind", act, r);
      chk(cyc == exp_lat, "R12", "result cycle", cyc, exp_lat);
      got = 1'b1;
    end
  end

  task automatic run_op(input bit st, input int cp, input logic [31:0] base,
                        input logic [7:0] off, input bit up, input bit pre, input bit wb,
                        input int nbusy, input bit cant, input int nbeats, input int fbeat,
                        input bit irq, input bit extra);
    bit perm, flt;
    int ndone;
    logic [31:0] tgt, first;
    perm = cp_present[cp] & cp_allowed[cp];
    tgt  = up ? base + {22'd0, off, 2'b00} : base - {22'd0, off, 2'b00};
    first = pre ? tgt : base;
    flt = (fbeat >= 0) && (fbeat < nbeats);
    ndone = flt ? fbeat + 1 : nbeats;
    if (!perm) begin
      exp_res.push_back(1); exp_lat = 2;
    end else if (cant) begin
      exp_res.push_back(1); exp_lat = nbusy + 2;
    end else begin
      if (wb) exp_wb.push_back(tgt);
      for (int i = 0; i < ndone; i++) begin
        exp_addr.push_back(first + 32'(4 * i));
        if (st) exp_wd.push_back(32'hC0DE_0000 + 32'(i));
      end
      if (flt) begin
        exp_res.push_back(2);
        if (wb) exp_wb.push_back(base);
      end else exp_res.push_back(0);
      exp_lat = nbusy + 2 + (st ? 0 : 1) + ndone;
    end
    @(posedge clk); #1;
    cfg_busy = nbusy; cfg_cant = cant; cfg_beats = nbeats; cfg_fault = fbeat;
    cur_store = st; irq_pending = irq; got = 1'b0;
    op_store = st; op_cp = CPW'(cp); op_base = base; op_off = off;
    op_up = up; op_pre = pre; op_wback = wb; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (extra) begin
      // R11: a second start while busy must change nothing
      @(posedge clk); #1;
      op_store = ~st; op_cp = 4'd7; op_base = 32'hFFFF_0000; op_pre = ~pre; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    wait (got);
    @(posedge clk); #1;
    chk(exp_addr.size() == 0 && exp_wb.size() == 0, "R8/R9", "scoreboard drained",
        32'(exp_addr.size() + exp_wb.size()), 0);
    chk(n_first == (perm ? 1 : 0), "R2/R3", "first-phase queries", n_first, perm ? 1 : 0);
    chk(n_intr == ((perm && irq) ? nbusy : 0), "R3", "interrupt polls", n_intr,
        (perm && irq) ? nbusy : 0);
    chk(n_poll == ((perm && !irq) ? nbusy : 0), "R3", "busy polls", n_poll,
        (perm && !irq) ? nbusy : 0);
    chk(n_xfer == ((perm && !cant && !st) ? 1 : 0), "R5", "transfer phases", n_xfer,
        (perm && !cant && !st) ? 1 : 0);
    chk(!busy, "R12", "idle after result", 32'(busy), 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; op_store = 1'b0; op_cp = '0; op_base = '0; op_off = '0;
    op_up = 1'b0; op_pre = 1'b0; op_wback = 1'b0; irq_pending = 1'b0;
    cp_present = 16'hFF7F; cp_allowed = 16'hBFFF;
    cfg_busy = 0; cfg_cant = 0; cfg_beats = 1; cfg_fault = -1; cur_store = 0; got = 0;
    exp_lat = 0; cyc = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!busy && !cp_req && !mem_req && !xfer_done && !trap_undef && !abort_data && !wb_en,
        "R1", "reset state", {25'd0, busy, cp_req, mem_req, xfer_done, trap_undef, abort_data, wb_en}, 0);
    // R5 R10: load, pre-indexed, add, writeback
    run_op(0, 3, 32'h0000_1000, 8'h10, 1, 1, 1, 0, 0, 3, -1, 0, 0);
    // R7 R10: store, post-indexed, subtract, polls without interrupt
    run_op(1, 5, 32'h0000_2000, 8'h04, 0, 0, 1, 2, 0, 2, -1, 0, 0);
    // R3: interrupt-phase polls, single beat, no writeback
    run_op(0, 1, 32'h0000_3000, 8'h00, 1, 1, 0, 3, 0, 1, -1, 1, 0);
    // R2: absent and not-permitted slots
    run_op(0, 7, 32'h0000_4000, 8'h01, 1, 1, 1, 0, 0, 2, -1, 0, 0);
    run_op(1, 14, 32'h0000_5000, 8'h01, 1, 1, 1, 0, 0, 2, -1, 0, 0);
    // R4: refusal after polls, and at the first query
    run_op(0, 2, 32'h0000_6000, 8'h02, 1, 1, 1, 2, 1, 2, -1, 0, 0);
    run_op(1, 2, 32'h0000_6000, 8'h02, 1, 1, 1, 0, 1, 2, -1, 1, 0);
    // R8 R9: load faults on second beat, base restored
    run_op(0, 4, 32'h0000_7000, 8'h08, 1, 0, 1, 1, 0, 3, 1, 0, 0);
    // R8 R9 R10: store faults on first beat, pre-indexed subtract
    run_op(1, 4, 32'h0000_8000, 8'h03, 0, 1, 1, 0, 0, 3, 0, 0, 0);
    // R11: extra start during a long store
    run_op(1, 9, 32'h0000_9000, 8'h05, 1, 1, 0, 1, 0, 4, -1, 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule